// File: doc/BRIEF.md
# Up/Down Event Counter with Threshold Flags

This block keeps a count that hardware moves up or down, one step per clock, from increment and decrement pulses. It raises a level flag while the count sits at or above an upper mark and another while it sits at or below a lower mark. It produces one-cycle strobes when the count wraps in either direction. Each direction can instead be set to stop at its limit, and a level flag then shows that the limit is held.

Software, or any other agent, loads the count through a write port and reads the present value on the count output. The width, both marks and both saturation choices are elaboration-time parameters. There are no run-time configuration registers.

Top module: `evc_counter`

## Requirements
- R1: A lone increment (increment high, decrement low, no write) adds one to the count. A lone decrement subtracts one. The new value appears on `count_o` after the clock edge that samples the pulse.
- R2: `hi_mark_o` is high exactly while `count_o` is greater than or equal to `HI_MARK`.
- R3: `lo_mark_o` is high exactly while `count_o` is less than or equal to `LO_MARK`.
- R4: With upper saturation disabled, a lone increment at the maximum value (all ones) takes the count to 0. `wrap_hi_o` is high for exactly the one cycle in which `count_o` first shows that 0, and is low at all other times.
- R5: With lower saturation disabled, a lone decrement at 0 takes the count to all ones. `wrap_lo_o` is high for exactly the one cycle in which `count_o` first shows that maximum, and is low at all other times.
- R6: With `SAT_HI` set, a lone increment at the maximum leaves the count at the maximum and gives no `wrap_hi_o` strobe. `sat_hi_o` is high while the count equals the maximum. With `SAT_HI` clear, `sat_hi_o` stays 0.
- R7: With `SAT_LO` set, a lone decrement at 0 leaves the count at 0 and gives no `wrap_lo_o` strobe. `sat_lo_o` is high while the count equals 0. With `SAT_LO` clear, `sat_lo_o` stays 0.
- R8: When increment and decrement are high in the same cycle, the count is unchanged and neither wrap strobe fires, even at either limit.
- R9: A write (`wr_en_i` high) loads `wr_data_i` into the count on that edge and wins over both pulses. No wrap strobe fires for the written value. The mark flags follow the loaded value in the next cycle.
- R10: A synchronous reset (`rst` high) clears the count and both strobes on the next edge, and wins over a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inc_i | input | 1 | Increment pulse |
| dec_i | input | 1 | Decrement pulse |
| wr_en_i | input | 1 | Load strobe |
| wr_data_i | input | WIDTH | Value to load |
| count_o | output | WIDTH | Present count |
| hi_mark_o | output | 1 | Count at or above HI_MARK |
| lo_mark_o | output | 1 | Count at or below LO_MARK |
| wrap_hi_o | output | 1 | One-cycle strobe after an upward wrap |
| wrap_lo_o | output | 1 | One-cycle strobe after a downward wrap |
| sat_hi_o | output | 1 | Count held at the maximum (saturating build) |
| sat_lo_o | output | 1 | Count held at zero (saturating build) |

## Verification
The bench builds two copies, both 4 bits wide with marks at 6 and 3. A 4-bit count lets either wrap be reached in a few steps, and both marks sit in the middle of the range. The first copy has both saturation options off, so it exercises the wrap strobes and shows that the saturation flags stay low. The second has both options on, so it shows the count held at 15 and at 0 with no strobe. A vector table drives the wrapping copy through counting, both mark crossings, both wraps, simultaneous pulses, writes that override pulses, and a reset that overrides a write.

// File: rtl/evc_pkg.sv
package evc_pkg;

   typedef enum logic [1:0] {
      MV_HOLD = 2'd0,
      MV_UP   = 2'd1,
      MV_DOWN = 2'd2
   } evc_move_e;

   function automatic evc_move_e evc_decode(input logic inc, input logic dec);
      if (inc && !dec)      return MV_UP;
      else if (dec && !inc) return MV_DOWN;
      else                  return MV_HOLD;
   endfunction

endpackage

// File: rtl/evc_step.sv
module evc_step
   import evc_pkg::*;
#(
   parameter int WIDTH  = 4,
   parameter bit SAT_HI = 1'b0,
   parameter bit SAT_LO = 1'b0
) (
   input  logic [WIDTH-1:0] cur_i,
   input  evc_move_e        move_i,
   output logic [WIDTH-1:0] nxt_o,
   output logic             wrap_hi_o,
   output logic             wrap_lo_o
);
   localparam logic [WIDTH-1:0] TOP = '1;
   localparam logic [WIDTH-1:0] BOT = '0;

   logic             at_top, at_bot;
   logic [WIDTH-1:0] up_val, dn_val;
   logic             up_wrap, dn_wrap;

   assign at_top = (cur_i == TOP);
   assign at_bot = (cur_i == BOT);

   generate
      if (SAT_HI) begin : g_up_sat
         assign up_val  = at_top ? cur_i : cur_i + 1'b1;
         assign up_wrap = 1'b0;
      end else begin : g_up_wrap
         assign up_val  = cur_i + 1'b1;
         assign up_wrap = at_top;
      end
      if (SAT_LO) begin : g_dn_sat
         assign dn_val  = at_bot ? cur_i : cur_i - 1'b1;
         assign dn_wrap = 1'b0;
      end else begin : g_dn_wrap
         assign dn_val  = cur_i - 1'b1;
         assign dn_wrap = at_bot;
      end
   endgenerate

   always_comb begin
      nxt_o     = cur_i;
      wrap_hi_o = 1'b0;
      wrap_lo_o = 1'b0;
      unique case (move_i)
         MV_UP: begin
            nxt_o     = up_val;
            wrap_hi_o = up_wrap;
         end
         MV_DOWN: begin
            nxt_o     = dn_val;
            wrap_lo_o = dn_wrap;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/evc_compare.sv
module evc_compare #(
   parameter int WIDTH   = 4,
   parameter int HI_MARK = 6,
   parameter int LO_MARK = 3,
   parameter bit SAT_HI  = 1'b0,
   parameter bit SAT_LO  = 1'b0
) (
   input  logic [WIDTH-1:0] cnt_i,
   output logic             hi_mark_o,
   output logic             lo_mark_o,
   output logic             sat_hi_o,
   output logic             sat_lo_o
);
   localparam logic [WIDTH-1:0] HI_V = WIDTH'(HI_MARK);
   localparam logic [WIDTH-1:0] LO_V = WIDTH'(LO_MARK);
   localparam logic [WIDTH-1:0] TOP  = '1;

   assign hi_mark_o = (cnt_i >= HI_V);
   assign lo_mark_o = (cnt_i <= LO_V);

   generate
      if (SAT_HI) begin : g_sat_hi
         assign sat_hi_o = (cnt_i == TOP);
      end else begin : g_nosat_hi
         assign sat_hi_o = 1'b0;
      end
      if (SAT_LO) begin : g_sat_lo
         assign sat_lo_o = (cnt_i == '0);
      end else begin : g_nosat_lo
         assign sat_lo_o = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/evc_counter.sv
module evc_counter
   import evc_pkg::*;
#(
   parameter int WIDTH   = 4,
   parameter int HI_MARK = 6,
   parameter int LO_MARK = 3,
   parameter bit SAT_HI  = 1'b0,
   parameter bit SAT_LO  = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             inc_i,
   input  logic             dec_i,
   input  logic             wr_en_i,
   input  logic [WIDTH-1:0] wr_data_i,
   output logic [WIDTH-1:0] count_o,
   output logic             hi_mark_o,
   output logic             lo_mark_o,
   output logic             wrap_hi_o,
   output logic             wrap_lo_o,
   output logic             sat_hi_o,
   output logic             sat_lo_o
);
   localparam logic [WIDTH-1:0] TOP = '1;

   initial begin : elab_checks
      assert (WIDTH >= 2 && WIDTH <= 64) else $error("evc_counter: WIDTH out of range");
      assert (HI_MARK >= 0 && HI_MARK < (64'd1 << WIDTH)) else $error("evc_counter: HI_MARK does not fit");
      assert (LO_MARK >= 0 && LO_MARK < (64'd1 << WIDTH)) else $error("evc_counter: LO_MARK does not fit");
   end

   logic [WIDTH-1:0] cnt_q, cnt_nxt;
   logic             whi_q, wlo_q, whi_nxt, wlo_nxt;
   evc_move_e        move;

   assign move = evc_decode(inc_i, dec_i);

   evc_step #(.WIDTH(WIDTH), .SAT_HI(SAT_HI), .SAT_LO(SAT_LO)) u_step (
      .cur_i     (cnt_q),
      .move_i    (move),
      .nxt_o     (cnt_nxt),
      .wrap_hi_o (whi_nxt),
      .wrap_lo_o (wlo_nxt)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
         whi_q <= 1'b0;
         wlo_q <= 1'b0;
      end else if (wr_en_i) begin
         cnt_q <= wr_data_i;
         whi_q <= 1'b0;
         wlo_q <= 1'b0;
      end else begin
         cnt_q <= cnt_nxt;
         whi_q <= whi_nxt;
         wlo_q <= wlo_nxt;
      end
   end

   evc_compare #(
      .WIDTH(WIDTH), .HI_MARK(HI_MARK), .LO_MARK(LO_MARK),
      .SAT_HI(SAT_HI), .SAT_LO(SAT_LO)
   ) u_cmp (
      .cnt_i     (cnt_q),
      .hi_mark_o (hi_mark_o),
      .lo_mark_o (lo_mark_o),
      .sat_hi_o  (sat_hi_o),
      .sat_lo_o  (sat_lo_o)
   );

   assign count_o   = cnt_q;
   assign wrap_hi_o = whi_q;
   assign wrap_lo_o = wlo_q;

   AST_WRAP_HI_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      wrap_hi_o |=> !wrap_hi_o);                                              // R4
   AST_WRAP_HI_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
      wrap_hi_o |-> (count_o == '0));                                         // R4
   AST_WRAP_LO_AT_TOP: assert property (@(posedge clk) disable iff (rst)
      wrap_lo_o |-> (count_o == TOP));                                        // R5
   AST_SAT_HI_HOLD: assert property (@(posedge clk) disable iff (rst)
      (SAT_HI && count_o == TOP && inc_i && !dec_i && !wr_en_i) |=> (count_o == TOP && !wrap_hi_o)); // R6
   AST_SAT_LO_HOLD: assert property (@(posedge clk) disable iff (rst)
      (SAT_LO && count_o == '0 && dec_i && !inc_i && !wr_en_i) |=> (count_o == '0 && !wrap_lo_o));  // R7
   AST_BOTH_PULSES_HOLD: assert property (@(posedge clk) disable iff (rst)
      (inc_i && dec_i && !wr_en_i) |=> ($stable(count_o) && !wrap_hi_o && !wrap_lo_o));              // R8
   AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (rst)
      wr_en_i |=> (count_o == $past(wr_data_i) && !wrap_hi_o && !wrap_lo_o)); // R9
   AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> (count_o == '0 && !wrap_hi_o && !wrap_lo_o));                   // R10

endmodule

// File: tb/tb_evc_counter.sv
`timescale 1ns/1ps
module tb_evc_counter;

   localparam int W  = 4;
   localparam int NV = 24;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic         rst, inc, dec, wr;
   logic [W-1:0] wdata;

   logic [W-1:0] cnt_a, cnt_b;
   logic hm_a, lm_a, wh_a, wl_a, sh_a, sl_a;
   logic hm_b, lm_b, wh_b, wl_b, sh_b, sl_b;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   evc_counter #(.WIDTH(W), .HI_MARK(6), .LO_MARK(3), .SAT_HI(1'b0), .SAT_LO(1'b0)) dut (
      .clk(clk), .rst(rst), .inc_i(inc), .dec_i(dec), .wr_en_i(wr), .wr_data_i(wdata),
      .count_o(cnt_a), .hi_mark_o(hm_a), .lo_mark_o(lm_a), .wrap_hi_o(wh_a),
      .wrap_lo_o(wl_a), .sat_hi_o(sh_a), .sat_lo_o(sl_a));

   evc_counter #(.WIDTH(W), .HI_MARK(6), .LO_MARK(3), .SAT_HI(1'b1), .SAT_LO(1'b1)) dut_sat (
      .clk(clk), .rst(rst), .inc_i(inc), .dec_i(dec), .wr_en_i(wr), .wr_data_i(wdata),
      .count_o(cnt_b), .hi_mark_o(hm_b), .lo_mark_o(lm_b), .wrap_hi_o(wh_b),
      .wrap_lo_o(wl_b), .sat_hi_o(sh_b), .sat_lo_o(sl_b));

   // Row: {req, {rst,wr,inc,dec}, wdata, exp count, exp {hi_mark,lo_mark,wrap_hi,wrap_lo}}
   localparam logic [19:0] VEC [NV] = '{
      {4'd10, 4'b1000, 4'd0,  4'd0,  4'b0100},  // R10 reset
      {4'd1,  4'b0010, 4'd0,  4'd1,  4'b0100},  // R1 count up
      {4'd1,  4'b0010, 4'd0,  4'd2,  4'b0100},
      {4'd3,  4'b0010, 4'd0,  4'd3,  4'b0100},  // R3 still at lower mark
      {4'd3,  4'b0010, 4'd0,  4'd4,  4'b0000},  // R3 leaves lower mark
      {4'd2,  4'b0010, 4'd0,  4'd5,  4'b0000},
      {4'd2,  4'b0010, 4'd0,  4'd6,  4'b1000},  // R2 reaches upper mark
      {4'd8,  4'b0011, 4'd0,  4'd6,  4'b1000},  // R8 both pulses
      {4'd2,  4'b0001, 4'd0,  4'd5,  4'b0000},  // R2 drops below mark
      {4'd9,  4'b0100, 4'd14, 4'd14, 4'b1000},  // R9 load
      {4'd1,  4'b0010, 4'd0,  4'd15, 4'b1000},
      {4'd4,  4'b0010, 4'd0,  4'd0,  4'b0110},  // R4 upward wrap strobe
      {4'd4,  4'b0000, 4'd0,  4'd0,  4'b0100},  // R4 strobe gone
      {4'd5,  4'b0001, 4'd0,  4'd15, 4'b1001},  // R5 downward wrap strobe
      {4'd5,  4'b0000, 4'd0,  4'd15, 4'b1000},  // R5 strobe gone
      {4'd9,  4'b0110, 4'd0,  4'd0,  4'b0100},  // R9 write beats inc at top
      {4'd9,  4'b0101, 4'd15, 4'd15, 4'b1000},  // R9 write beats dec at zero
      {4'd8,  4'b0011, 4'd0,  4'd15, 4'b1000},  // R8 both pulses at top
      {4'd10, 4'b1100, 4'd5,  4'd0,  4'b0100},  // R10 reset beats write
      {4'd5,  4'b0001, 4'd0,  4'd15, 4'b1001},  // R5 wrap again
      {4'd10, 4'b1000, 4'd0,  4'd0,  4'b0100},  // R10 reset clears strobe
      {4'd9,  4'b0100, 4'd3,  4'd3,  4'b0100},  // R9 marks follow load
      {4'd9,  4'b0100, 4'd7,  4'd7,  4'b1000},  // R9 marks follow load
      {4'd1,  4'b0001, 4'd0,  4'd6,  4'b1000}   // R1 count down
   };

   task automatic drive(input logic r, input logic w, input logic i, input logic d,
                        input logic [W-1:0] v);
      @(negedge clk);
      rst = r; wr = w; inc = i; dec = d; wdata = v;
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0; wr = 1'b0; inc = 1'b0; dec = 1'b0;
   endtask

   task automatic chk_sat(input string req, input logic [W-1:0] ec,
                          input logic esh, input logic esl);
      n_chk++;
      if (cnt_b !== ec || sh_b !== esh || sl_b !== esl || wh_b !== 1'b0 || wl_b !== 1'b0) begin
         n_fail++;
         $display("FAIL %s: got cnt=%0d sat_hi=%b sat_lo=%b wh=%b wl=%b, expected cnt=%0d sat_hi=%b sat_lo=%b wh=0 wl=0",
                  req, cnt_b, sh_b, sl_b, wh_b, wl_b, ec, esh, esl);
      end
   endtask

   initial begin : watchdog
      #(4 * 20000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got hung run, expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : main
      rst = 1'b1; wr = 1'b0; inc = 1'b0; dec = 1'b0; wdata = '0;
      @(posedge clk);
      @(negedge clk);
      // R10 reset state
      n_chk++;
      if (cnt_a !== 4'd0 || wh_a !== 1'b0 || wl_a !== 1'b0) begin
         n_fail++;
         $display("FAIL R10: got cnt=%0d wh=%b wl=%b, expected 0 0 0", cnt_a, wh_a, wl_a);
      end

      for (int k = 0; k < NV; k++) begin
         logic [19:0] row;
         row = VEC[k];
         drive(row[15], row[14], row[13], row[12], row[11:8]);
         n_chk++;
         if (cnt_a !== row[7:4] || {hm_a, lm_a, wh_a, wl_a} !== row[3:0]) begin
            n_fail++;
            $display("FAIL R%0d row %0d: got cnt=%0d flags=%b, expected cnt=%0d flags=%b",
                     row[19:16], k, cnt_a, {hm_a, lm_a, wh_a, wl_a}, row[7:4], row[3:0]);
         end
         // R6 and R7: wrapping build never shows saturation
         n_chk++;
         if (sh_a !== 1'b0 || sl_a !== 1'b0) begin
            n_fail++;
            $display("FAIL R6/R7 row %0d: got sat_hi=%b sat_lo=%b, expected 0 0", k, sh_a, sl_a);
         end
      end

      // Directed corner cases on the saturating build
      drive(1'b1, 1'b0, 1'b0, 1'b0, 4'd0);
      chk_sat("R10", 4'd0, 1'b0, 1'b1);
      drive(1'b0, 1'b1, 1'b0, 1'b0, 4'd14);
      chk_sat("R9", 4'd14, 1'b0, 1'b0);
      drive(1'b0, 1'b0, 1'b1, 1'b0, 4'd0);
      chk_sat("R6", 4'd15, 1'b1, 1'b0);
      drive(1'b0, 1'b0, 1'b1, 1'b0, 4'd0);
      chk_sat("R6", 4'd15, 1'b1, 1'b0);
      drive(1'b0, 1'b0, 1'b1, 1'b0, 4'd0);
      chk_sat("R6", 4'd15, 1'b1, 1'b0);
      drive(1'b0, 1'b1, 1'b0, 1'b0, 4'd1);
      chk_sat("R9", 4'd1, 1'b0, 1'b0);
      drive(1'b0, 1'b0, 1'b0, 1'b1, 4'd0);
      chk_sat("R7", 4'd0, 1'b0, 1'b1);
      drive(1'b0, 1'b0, 1'b0, 1'b1, 4'd0);
      chk_sat("R7", 4'd0, 1'b0, 1'b1);
      drive(1'b0, 1'b0, 1'b1, 1'b1, 4'd0);
      chk_sat("R8", 4'd0, 1'b0, 1'b1);
      drive(1'b0, 1'b0, 1'b1, 1'b0, 4'd0);
      chk_sat("R1", 4'd1, 1'b0, 1'b0);

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule